// File: doc/BRIEF.md
# History-Majority Branch Direction Predictor

This block predicts whether a branch will be taken. It has a direct-mapped table with one entry per slot, and low program-counter bits select the entry. Each entry keeps a short record of the most recent resolved outcomes for the branches that map to it. It also counts how many outcomes it has recorded so far, up to the length of the record.

Once an entry's record is full, conditional and loop branches are predicted by majority vote over the recorded outcomes. Until then, the block uses a fixed rule chosen by branch class. Unconditional jumps and call/return are always predicted taken.

The fetch stage presents a lookup and receives the registered prediction one clock later. The resolve stage reports each actual outcome through a separate update port.

Top module: `bpred_majority`

## Requirements
- R1: Reset clears every outcome record and every fill count, so each entry starts out unfilled.
- R2: `pred_valid` is high exactly one cycle after a cycle with `lk_valid` high. `pred_taken` is low whenever `pred_valid` is low.
- R3: Branch class codes 2'b10 (unconditional) and 2'b11 (call/return) are predicted taken whatever the entry holds.
- R4: Branch class 2'b00 (conditional) is predicted not taken while its entry has recorded fewer than three outcomes.
- R5: Branch class 2'b01 (loop) is predicted taken while its entry has recorded fewer than three outcomes.
- R6: Once an entry has recorded three outcomes, classes 2'b00 and 2'b01 are predicted taken when at least two of the three recorded outcomes were taken, and not taken otherwise.
- R7: An update shifts the actual outcome into bit 0 of the entry's record and drops the oldest bit, so the vote always covers the three most recent outcomes.
- R8: The entry is selected by PC bits [5:2]. PCs that differ only above bit 5 share an entry. Entries with different indices are independent.
- R9: When a lookup and an update address the same entry in the same cycle, the prediction uses the entry's contents from before that update.
- R10: The fill count saturates at three. Further updates keep the entry in majority-vote mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Program counter of the branch being looked up |
| lk_kind | input | 2 | Branch class: 00 conditional, 01 loop, 10 unconditional, 11 call/return |
| upd_valid | input | 1 | Resolved outcome is presented this cycle |
| upd_pc | input | PC_W | Program counter of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| pred_valid | output | 1 | Prediction available, one cycle after lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
The checker runs on every cycle. It checks the one-cycle lookup-to-prediction timing and that an idle output is never marked taken. It checks that unconditional and call/return classes always come out taken, and that unfilled entries follow the class rule for conditional and loop branches. It also checks that every fill count is zero when reset is released.

The rest depends on a specific order of stimulus and is shown only by the bench's scenarios:
- the majority vote;
- the oldest-bit eviction from the record;
- index aliasing between PCs;
- the read-before-update order when a lookup and an update share an entry;
- the reset of learned history in the middle of a run.

// File: rtl/bpred_majority.sv
module bpred_majority #(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int IDX_LSB = 2,
  parameter int HIST_W  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  input  logic [1:0]      lk_kind,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            pred_valid,
  output logic            pred_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(HIST_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HIST_W);
  localparam logic [1:0] K_COND = 2'b00;
  localparam logic [1:0] K_LOOP = 2'b01;

  logic [ENTRIES-1:0][HIST_W-1:0] hist_q;
  logic [ENTRIES-1:0][CNT_W-1:0]  fill_q;

  logic [IDX_W-1:0] lk_idx, upd_idx;
  assign lk_idx  = lk_pc[IDX_LSB +: IDX_W];
  assign upd_idx = upd_pc[IDX_LSB +: IDX_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_LSB+IDX_W], lk_pc[IDX_LSB-1:0],
                            upd_pc[PC_W-1:IDX_LSB+IDX_W], upd_pc[IDX_LSB-1:0]};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic hit;
    assign hit = upd_valid && (upd_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q[i] <= '0;
        fill_q[i] <= '0;
      end else if (hit) begin
        hist_q[i] <= {hist_q[i][HIST_W-2:0], upd_taken};
        if (fill_q[i] != FULL) fill_q[i] <= fill_q[i] + 1'b1;
      end
    end
  end

  logic [HIST_W-1:0] rd_hist;
  logic              rd_full, vote, static_dir, next_dir;
  assign rd_hist    = hist_q[lk_idx];
  assign rd_full    = (fill_q[lk_idx] == FULL);
  assign vote       = ($countones(rd_hist) > (HIST_W / 2));
  assign static_dir = (lk_kind != K_COND);

  always_comb begin
    if (lk_kind == K_COND || lk_kind == K_LOOP)
      next_dir = rd_full ? vote : static_dir;
    else
      next_dir = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      pred_taken <= lk_valid & next_dir;
    end
  end
endmodule

// File: rtl/bpred_majority_chk.sv
module bpred_majority_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 2,
  parameter int FULL    = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          lk_valid,
  input logic [1:0]                    lk_kind,
  input logic [IDX_W-1:0]              lk_idx,
  input logic [ENTRIES-1:0][CNT_W-1:0] fill,
  input logic                          pred_valid,
  input logic                          pred_taken
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid); // R2
  AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid); // R2
  AST_IDLE_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> !pred_taken); // R2
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind[1]) |=> pred_taken); // R3
  AST_COLD_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'b00 && fill[lk_idx] != CNT_W'(FULL)) |=> !pred_taken); // R4
  AST_COLD_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind == 2'b01 && fill[lk_idx] != CNT_W'(FULL)) |=> pred_taken); // R5
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fill == '0)); // R1
endmodule

bind bpred_majority bpred_majority_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W), .FULL(HIST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
  .lk_idx(lk_idx), .fill(fill_q), .pred_valid(pred_valid), .pred_taken(pred_taken)
);

// File: tb/bpred_majority_tb.sv
module bpred_majority_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [1:0]  lk_kind = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred_valid, pred_taken;

  int errors = 0;
  int checks = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bpred_majority u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .pred_valid(pred_valid), .pred_taken(pred_taken)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (pred_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected prediction act=%0b exp=none", pred_taken);
        end else begin
          automatic bit e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          if (pred_taken !== e) begin
            errors++;
            $display("FAIL %s: pred_taken act=%0b exp=%0b", t, pred_taken, e);
          end
        end
      end else if (pred_taken !== 1'b0) begin
        checks++; errors++;
        $display("FAIL R2: idle pred_taken act=%0b exp=0", pred_taken);
      end
    end
  end

  task automatic cyc(input bit lv, input logic [31:0] lpc, input logic [1:0] k,
                     input bit e, input string t,
                     input bit uv, input logic [31:0] upc, input bit ut);
    @(negedge clk);
    lk_valid = lv; lk_pc = lpc; lk_kind = k;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    if (lv) begin exp_q.push_back(e); tag_q.push_back(t); end
  endtask

  task automatic look(input logic [31:0] pc, input logic [1:0] k, input bit e, input string t);
    cyc(1'b1, pc, k, e, t, 1'b0, '0, 1'b0);
  endtask

  task automatic upd(input logic [31:0] pc, input bit tk);
    cyc(1'b0, '0, 2'b00, 1'b0, "", 1'b1, pc, tk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 2'b00, 1'b0, "", 1'b0, '0, 1'b0);
  endtask

  task automatic expect_drained(input string t);
    checks++;
    if (exp_q.size() != 0 || pred_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: pending=%0d pred_valid act=%0b exp=0", t, exp_q.size(), pred_valid);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pred_valid !== 1'b0 || pred_taken !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset outputs act=%0b%0b exp=00", pred_valid, pred_taken);
    end
    rst_n = 1'b1;

    // R1 R4 R5 R3: cold entry
    look(32'h100, 2'b00, 1'b0, "R4");
    look(32'h100, 2'b01, 1'b1, "R5");
    look(32'h100, 2'b10, 1'b1, "R3");
    look(32'h100, 2'b11, 1'b1, "R3");

    // entry 1: two outcomes, still static
    upd(32'h04, 1'b1);
    upd(32'h04, 1'b1);
    look(32'h04, 2'b00, 1'b0, "R4");
    look(32'h04, 2'b01, 1'b1, "R5");
    upd(32'h04, 1'b0);                 // T,T,N
    look(32'h04, 2'b00, 1'b1, "R6");
    look(32'h04, 2'b01, 1'b1, "R6");
    upd(32'h04, 1'b0);                 // T,N,N
    look(32'h04, 2'b00, 1'b0, "R7");
    look(32'h04, 2'b01, 1'b0, "R6");
    look(32'h04, 2'b11, 1'b1, "R3");
    upd(32'h04, 1'b0);                 // N,N,N
    upd(32'h04, 1'b1);                 // N,N,T
    look(32'h04, 2'b00, 1'b0, "R10");
    upd(32'h04, 1'b1);                 // N,T,T
    look(32'h04, 2'b00, 1'b1, "R10");

    // R8: alias and independence
    look(32'h44, 2'b00, 1'b1, "R8");
    look(32'h1004, 2'b00, 1'b1, "R8");
    look(32'h08, 2'b00, 1'b0, "R8");
    look(32'h08, 2'b01, 1'b1, "R8");

    // R9: same-cycle lookup and update, full entry
    upd(32'h0C, 1'b1);
    upd(32'h0C, 1'b1);
    upd(32'h0C, 1'b0);
    cyc(1'b1, 32'h0C, 2'b00, 1'b1, "R9", 1'b1, 32'h0C, 1'b0);
    look(32'h0C, 2'b00, 1'b0, "R9");
    // R9 at fill boundary
    upd(32'h10, 1'b1);
    upd(32'h10, 1'b1);
    cyc(1'b1, 32'h10, 2'b00, 1'b0, "R9", 1'b1, 32'h10, 1'b1);
    look(32'h10, 2'b00, 1'b1, "R9");
    // lookup on another entry during update: unaffected
    cyc(1'b1, 32'h14, 2'b00, 1'b0, "R8", 1'b1, 32'h10, 1'b0);

    idle(3);
    expect_drained("R2");

    // R1: reset in mid-run wipes learned history
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(32'h04, 2'b00, 1'b0, "R1");
    look(32'h0C, 2'b01, 1'b1, "R1");
    idle(3);
    expect_drained("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule